// File: doc/BRIEF.md
# USB Host Port Connection Monitor

This block watches one downstream host port and decides whether a device is connected to it. Each clock it takes the decoded two-bit line state. It reports a connection once the line has moved into an idle or resume level and then held that level long enough. It reports a disconnection once the line has sat at single-ended zero for the same interval while a device is present. Both intervals are a count of system clocks set by one parameter. The default is 500 cycles, which is 2.5 µs at 200 MHz.

When a disconnection is seen, the block acts on its own. It drops the port-active flag and returns the port to idle, whatever the interrupt enables say. Software can then shut down its traffic and wait for the next connection report. Each event sets a sticky status bit, and software clears it with a write-one strobe. A single interrupt request combines the enabled status bits. Detection runs only while host operation is enabled.

Top module: `usb_port_conn_mon`

## Requirements
- R1: After reset, both status bits, `irq` and `port_active` are 0, and `port_idle` is 1.
- R2: Line codes are 00 = SE0, 01 = J, 10 = K, 11 = SE1. In idle, when the line changes to J and stays at J, `attach_sts` rises and `port_idle` falls on the STABLE_CYC-th consecutive rising edge that samples J. The count includes the edge where the change is first sampled. One edge earlier, neither output has moved.
- R3: The same qualification applies when the line changes into K and stays at K.
- R4: A J or K run that ends before STABLE_CYC edges produces no attach. The count restarts at the next change. A run of SE0 or SE1, however long, never produces an attach.
- R5: While attached, SE0 held for STABLE_CYC consecutive edges sets `detach_sts`, clears `port_active` and sets `port_idle` on that edge. This happens even with `detach_ie` at 0.
- R6: A single non-SE0 sample inside an SE0 run restarts the disconnect count.
- R7: No detach is reported while the port is idle. No attach is reported while the port is attached, even across J/K changes.
- R8: While `host_en` is 0, no attach or detach is reported and the port state holds. A level that is already present when `host_en` returns does not qualify; a fresh change is needed.
- R9: Status bits stay set until their clear strobe is sampled at a rising edge. If a set and a clear happen at the same edge, the set wins.
- R10: `irq` is a register. After each edge it equals (attach_sts AND attach_ie) OR (detach_sts AND detach_ie), using the status after that edge and the enables sampled at that edge.
- R11: `port_act_set` sets `port_active` only while the port is attached. In idle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host operation selected; enables detection |
| line_st | input | 2 | Sampled line state (00 SE0, 01 J, 10 K, 11 SE1) |
| attach_ie | input | 1 | Attach interrupt enable |
| detach_ie | input | 1 | Detach interrupt enable |
| attach_clr | input | 1 | Write-one clear strobe for attach status |
| detach_clr | input | 1 | Write-one clear strobe for detach status |
| port_act_set | input | 1 | Software request to mark the port active |
| attach_sts | output | 1 | Sticky attach status |
| detach_sts | output | 1 | Sticky detach status |
| irq | output | 1 | Registered interrupt request |
| port_active | output | 1 | Port-active flag |
| port_idle | output | 1 | Port is idle, waiting for a connection |

## Verification
The status bits, the port state, `port_active` and `irq` are all due on one edge. That edge is the STABLE_CYC-th consecutive edge at which the bench holds a level, counting the first edge that sees the new level. A strobe or an enable change takes effect on the very next edge. The bench changes inputs and samples outputs on falling edges. Each held level therefore spans an exact number of rising edges. Every boundary is checked at both the STABLE_CYC-1 edge and the STABLE_CYC edge, so an off-by-one in either direction is seen.

// File: rtl/usbmon_pkg.sv
package usbmon_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic {
    PORT_IDLE = 1'b0,
    PORT_ATT  = 1'b1
  } port_e;
endpackage

// File: rtl/usbmon_line_timer.sv
// Counts consecutive edges at which the line level is unchanged. A run only
// counts when it began with a change seen while host operation was enabled.
module usbmon_line_timer
  import usbmon_pkg::*;
#(
  parameter int STABLE_CYC = 500
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  host_en,
  input  line_e line_st,
  output logic  hit,
  output line_e hit_state
);
  localparam int CNT_W = $clog2(STABLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(STABLE_CYC);

  line_e            ls_q;
  logic [CNT_W-1:0] run_cnt;
  logic             same;

  assign same      = (line_st == ls_q);
  assign hit       = host_en && same && (run_cnt == CNT_LAST);
  assign hit_state = line_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q    <= LS_SE0;
      run_cnt <= '0;
    end else begin
      ls_q <= line_st;
      if (!host_en)
        run_cnt <= '0;
      else if (!same)
        run_cnt <= CNT_W'(1);
      else if (run_cnt != '0 && run_cnt != CNT_MAX)
        run_cnt <= run_cnt + CNT_W'(1);
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CNT_MAX);
  assert_off_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
    !host_en |-> !hit);
endmodule

// File: rtl/usbmon_conn_fsm.sv
// Attached/idle state of the port and the port-active flag.
module usbmon_conn_fsm
  import usbmon_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hit,
  input  line_e hit_state,
  input  logic  port_act_set,
  output logic  attach_evt,
  output logic  detach_evt,
  output logic  port_idle,
  output logic  port_active
);
  port_e state_q;

  assign attach_evt = hit && (state_q == PORT_IDLE) &&
                      (hit_state == LS_J || hit_state == LS_K);
  assign detach_evt = hit && (state_q == PORT_ATT) && (hit_state == LS_SE0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PORT_IDLE;
      port_active <= 1'b0;
    end else begin
      if (attach_evt)
        state_q <= PORT_ATT;
      else if (detach_evt)
        state_q <= PORT_IDLE;
      if (detach_evt)
        port_active <= 1'b0;
      else if (port_act_set && state_q == PORT_ATT)
        port_active <= 1'b1;
    end
  end

  assign port_idle = (state_q == PORT_IDLE);

  assert_detach_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(port_idle) |-> !port_active);
  assert_act_only_att_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(port_active) |-> !port_idle);
  assert_one_event_R7: assert property (@(posedge clk) disable iff (rst)
    !(attach_evt && detach_evt));
endmodule

// File: rtl/usbmon_irq.sv
// Sticky status bits with write-one clear and a registered interrupt request.
module usbmon_irq (
  input  logic clk,
  input  logic rst,
  input  logic attach_set,
  input  logic detach_set,
  input  logic attach_clr,
  input  logic detach_clr,
  input  logic attach_ie,
  input  logic detach_ie,
  output logic attach_sts,
  output logic detach_sts,
  output logic irq
);
  logic att_d, det_d;

  always_comb begin
    att_d = attach_set | (attach_sts & ~attach_clr);
    det_d = detach_set | (detach_sts & ~detach_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      attach_sts <= 1'b0;
      detach_sts <= 1'b0;
      irq        <= 1'b0;
    end else begin
      attach_sts <= att_d;
      detach_sts <= det_d;
      irq        <= (att_d & attach_ie) | (det_d & detach_ie);
    end
  end

  assert_sticky_att_R9: assert property (@(posedge clk) disable iff (rst)
    (attach_sts && !attach_clr) |=> attach_sts);
  assert_sticky_det_R9: assert property (@(posedge clk) disable iff (rst)
    (detach_sts && !detach_clr) |=> detach_sts);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    attach_set |=> attach_sts);
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (attach_sts || detach_sts));
endmodule

// File: rtl/usb_port_conn_mon.sv
module usb_port_conn_mon
  import usbmon_pkg::*;
#(
  parameter int STABLE_CYC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_en,
  input  logic [1:0] line_st,
  input  logic       attach_ie,
  input  logic       detach_ie,
  input  logic       attach_clr,
  input  logic       detach_clr,
  input  logic       port_act_set,
  output logic       attach_sts,
  output logic       detach_sts,
  output logic       irq,
  output logic       port_active,
  output logic       port_idle
);
  line_e ls_in, hit_state;
  logic  hit, attach_evt, detach_evt;

  assign ls_in = line_e'(line_st);

  usbmon_line_timer #(.STABLE_CYC(STABLE_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .host_en   (host_en),
    .line_st   (ls_in),
    .hit       (hit),
    .hit_state (hit_state)
  );

  usbmon_conn_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .hit          (hit),
    .hit_state    (hit_state),
    .port_act_set (port_act_set),
    .attach_evt   (attach_evt),
    .detach_evt   (detach_evt),
    .port_idle    (port_idle),
    .port_active  (port_active)
  );

  usbmon_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .attach_set (attach_evt),
    .detach_set (detach_evt),
    .attach_clr (attach_clr),
    .detach_clr (detach_clr),
    .attach_ie  (attach_ie),
    .detach_ie  (detach_ie),
    .attach_sts (attach_sts),
    .detach_sts (detach_sts),
    .irq        (irq)
  );

  assert_off_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !host_en |=> $stable(port_idle));
endmodule

// File: tb/tb_usb_port_conn_mon.sv
module tb_usb_port_conn_mon;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ST = 20;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_en = 1'b1;
  logic [1:0] line_st = SE0;
  logic attach_ie = 1'b0, detach_ie = 1'b0;
  logic attach_clr = 1'b0, detach_clr = 1'b0, port_act_set = 1'b0;
  logic attach_sts, detach_sts, irq, port_active, port_idle;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_port_conn_mon #(.STABLE_CYC(ST)) dut (
    .clk(clk), .rst(rst), .host_en(host_en), .line_st(line_st),
    .attach_ie(attach_ie), .detach_ie(detach_ie),
    .attach_clr(attach_clr), .detach_clr(detach_clr),
    .port_act_set(port_act_set),
    .attach_sts(attach_sts), .detach_sts(detach_sts), .irq(irq),
    .port_active(port_active), .port_idle(port_idle)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // caller is at a falling edge; level spans n rising edges
  task automatic hold(input logic [1:0] ls, input int n);
    line_st = ls;
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_att();
    attach_clr = 1'b1; @(negedge clk); attach_clr = 1'b0;
  endtask

  task automatic clr_det();
    detach_clr = 1'b1; @(negedge clk); detach_clr = 1'b0;
  endtask

  task automatic act_set();
    port_act_set = 1'b1; @(negedge clk); port_act_set = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "attach_sts", attach_sts, 1'b0);
    chk("R1", "detach_sts", detach_sts, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "port_active", port_active, 1'b0);
    chk("R1", "port_idle", port_idle, 1'b1);
  endtask

  task automatic t_attach_j();
    attach_ie = 1'b1;
    hold(J, ST - 1);
    chk("R2", "attach_sts one edge early", attach_sts, 1'b0);
    chk("R2", "port_idle one edge early", port_idle, 1'b1);
    hold(J, 1);
    chk("R2", "attach_sts", attach_sts, 1'b1);
    chk("R2", "port_idle", port_idle, 1'b0);
    chk("R10", "irq with attach enabled", irq, 1'b1);
    clr_att();
    chk("R9", "attach_sts cleared", attach_sts, 1'b0);
    chk("R10", "irq after clear", irq, 1'b0);
    act_set();
    chk("R11", "port_active set when attached", port_active, 1'b1);
  endtask

  task automatic t_no_reattach();
    hold(K, ST + 2);
    chk("R7", "no attach while attached", attach_sts, 1'b0);
    chk("R7", "still attached", port_idle, 1'b0);
  endtask

  task automatic t_detach();
    detach_ie = 1'b0;
    hold(SE0, ST - 1);
    hold(J, 1);
    hold(SE0, ST - 1);
    chk("R6", "no detach after restart", detach_sts, 1'b0);
    chk("R6", "still attached", port_idle, 1'b0);
    hold(SE0, 1);
    chk("R5", "detach_sts", detach_sts, 1'b1);
    chk("R5", "port_active cleared", port_active, 1'b0);
    chk("R5", "port_idle", port_idle, 1'b1);
    chk("R10", "irq masked", irq, 1'b0);
    detach_ie = 1'b1;
    @(negedge clk);
    chk("R10", "irq after enable", irq, 1'b1);
    clr_det();
    chk("R9", "detach_sts cleared", detach_sts, 1'b0);
  endtask

  task automatic t_idle_no_detach();
    hold(SE0, ST + 5);
    chk("R7", "no detach in idle", detach_sts, 1'b0);
  endtask

  task automatic t_attach_k();
    act_set();
    chk("R11", "set ignored in idle", port_active, 1'b0);
    hold(K, ST - 1);
    chk("R3", "no attach one edge early", attach_sts, 1'b0);
    attach_clr = 1'b1;
    hold(K, 1);
    attach_clr = 1'b0;
    chk("R9", "set wins over clear", attach_sts, 1'b1);
    chk("R3", "port_idle after K", port_idle, 1'b0);
    clr_att();
  endtask

  task automatic t_short_run();
    hold(SE0, ST);
    clr_det();
    hold(J, ST - 1);
    hold(SE1, ST + 3);
    chk("R4", "short J and long SE1", attach_sts, 1'b0);
    chk("R4", "idle kept", port_idle, 1'b1);
    hold(J, ST - 1);
    chk("R4", "restart not yet qualified", attach_sts, 1'b0);
    hold(J, 1);
    chk("R4", "restart qualifies", attach_sts, 1'b1);
    clr_att();
  endtask

  task automatic t_host_off();
    hold(SE0, ST);
    clr_det();
    host_en = 1'b0;
    hold(J, ST + 3);
    chk("R8", "no attach while off", attach_sts, 1'b0);
    chk("R8", "idle while off", port_idle, 1'b1);
    host_en = 1'b1;
    hold(J, ST + 3);
    chk("R8", "no attach without change", attach_sts, 1'b0);
    hold(K, ST);
    chk("R8", "attach after change", attach_sts, 1'b1);
    host_en = 1'b0;
    hold(SE0, ST + 3);
    chk("R8", "no detach while off", detach_sts, 1'b0);
    chk("R8", "attached held while off", port_idle, 1'b0);
    host_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_attach_j();
    t_no_reattach();
    t_detach();
    t_idle_no_detach();
    t_attach_k();
    t_short_run();
    t_host_off();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule